// File: doc/BRIEF.md
# Dual-Half Multi-Mode Timer

This block holds a pair of 16-bit timer/counters, half 0 and half 1, behind a small register port. Each half can run alone in one of five modes: one-shot countdown, periodic countdown, input edge counting, input edge time capture, or simple PWM with selectable polarity. Setting the join bit fuses half 0 and half 1 into one 32-bit counter that runs through half 0's registers. In that joined state the counter can also act as a real-time clock that advances on a slow external tick.

Software writes the configuration, load, match and prescale registers, then sets a per-half enable. Timeout, capture and match events set sticky status bits. Each status bit has its own interrupt mask, and the interrupt output is high while any unmasked status bit is set. A debug-halt input can freeze the countdown modes of any half whose stall bit is set. The capture pins, the tick and the halt input are taken to be synchronous to the clock already.

Top module: `gp_timer_pair`

## Requirements
- R1: After reset, every register reads 0, both PWM outputs are low and the interrupt output is low.
- R2: One-shot (mode code 0). Writing a half's LOAD register (addresses 2 and 3) copies the value into that half's counter. Once enabled (CTRL at address 1, bit h), the counter steps down once per tick. The tick after the counter reaches 0 sets the half's timeout status bit. The counter then stays at 0 and the enable bit clears.
- R3: Periodic (mode code 1) works like one-shot. The difference is that on the timeout tick the counter reloads from LOAD and the enable bit stays set, so timeouts repeat every LOAD+1 ticks.
- R4: In unjoined countdown modes a tick occurs once every PRE+1 enabled, unfrozen cycles. PRE is the half's 8-bit prescale register, at addresses 6 and 7. In joined mode every cycle is a tick.
- R5: With the join bit set (CONFIG bit 0), half 0 counts with full 32-bit width and borrows across bit 16. Half 1 stays idle even if its enable bit is set.
- R6: With join and the clock bit (CONFIG bit 1) both set, the counter of half 0 increments on each cycle with the tick input high. The match status bit is set when the new count equals MATCH.
- R7: When a half's stall bit (CONFIG bit 8+h) is set and the halt input is high, that half's countdown counter and prescaler hold their values. A half whose stall bit is clear keeps counting.
- R8: Edge count (mode code 2). The counter increments on each selected pin edge. The edge select field is CONFIG[13+2h:12+2h]: 0 rising, 1 falling, 2 or 3 both. The match status bit is set when the new count equals MATCH (addresses 4 and 5).
- R9: Edge time (mode code 3). The counter counts down every cycle, reloading from LOAD after 0. On a selected edge it copies the counter into CAPTURE (addresses 12 and 13) and sets the capture status bit.
- R10: PWM (mode code 4). The counter counts down every cycle, reloading from LOAD after 0. The output is high while the count exceeds MATCH and is XOR-ed with the invert bit (CONFIG bit 10+h). Reaching MATCH sets the match status bit.
- R11: STATUS (address 8) holds bit 3h+0 timeout, 3h+1 capture and 3h+2 match for each half h. Bits are sticky and cleared by writing 1 to them; a new event in the same cycle wins over the clear. The interrupt output is the OR of STATUS AND MASK (address 9).
- R12: A LOAD write while a half is counting replaces its counter value at once and restarts its prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Register read data, combinational |
| ccp_a_i | input | 1 | Capture input of half 0 |
| ccp_b_i | input | 1 | Capture input of half 1 |
| rtc_tick_i | input | 1 | Slow clock tick, one cycle per count |
| dbg_halt_i | input | 1 | Debug halt request |
| pwm_a_o | output | 1 | PWM output of half 0 |
| pwm_b_o | output | 1 | PWM output of half 1 |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the borrow across bit 16 in joined mode, together with proof that half 1 stays silent. The stimulus loads 0x10001 into a joined one-shot with both enable bits set. It then lets the full 65,538-cycle countdown run while a per-cycle reference follows the counter through the 0x10000 to 0xFFFF step. At the end it checks that only half 0's timeout bit is set, although a running half 1 with a zero load would have timed out at once. Halt stalling and a LOAD write in mid-count are both reached by driving the halt input before the enable and by writing LOAD while a periodic count is already under way.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam logic [2:0] MD_ONESHOT  = 3'd0;
  localparam logic [2:0] MD_PERIODIC = 3'd1;
  localparam logic [2:0] MD_EDGECNT  = 3'd2;
  localparam logic [2:0] MD_EDGETIME = 3'd3;
  localparam logic [2:0] MD_PWM      = 3'd4;

  localparam int CFG_W    = 16;
  localparam int CF_JOIN  = 0;
  localparam int CF_RTC   = 1;
  localparam int CF_MODE  = 2;
  localparam int CF_STALL = 8;
  localparam int CF_INV   = 10;
  localparam int CF_EDGE  = 12;

  localparam int A_CFG   = 0;
  localparam int A_CTRL  = 1;
  localparam int A_LOAD  = 2;
  localparam int A_MATCH = 4;
  localparam int A_PRE   = 6;
  localparam int A_STAT  = 8;
  localparam int A_MASK  = 9;
  localparam int A_CNT   = 10;
  localparam int A_CAP   = 12;

  function automatic logic edge_hit(input logic [1:0] sel, input logic cur, input logic prev);
    case (sel)
      2'd0:    return cur & ~prev;
      2'd1:    return ~cur & prev;
      default: return cur ^ prev;
    endcase
  endfunction
endpackage

// File: rtl/gpt_half.sv
module gpt_half import gpt_pkg::*; #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               wide,
  input  logic               rtc_mode,
  input  logic [2:0]         mode,
  input  logic               stall_en,
  input  logic               halt,
  input  logic               inv,
  input  logic [1:0]         edge_sel,
  input  logic               pin,
  input  logic               rtc_tick,
  input  logic               load_wr,
  input  logic [2*CNT_W-1:0] wr_val,
  input  logic [2*CNT_W-1:0] load_val,
  input  logic [2*CNT_W-1:0] match_val,
  input  logic [PRE_W-1:0]   pre_val,
  output logic [2*CNT_W-1:0] cnt,
  output logic [2*CNT_W-1:0] cap,
  output logic               ev_timeout,
  output logic               ev_capture,
  output logic               ev_match,
  output logic               done,
  output logic               pwm_o
);
  localparam int DW = 2 * CNT_W;

  logic [DW-1:0]    cnt_q, cap_q, msk, lim, upd;
  logic [PRE_W-1:0] pre_q;
  logic             pin_q;
  logic             edge_ev, is_cd, frozen, tick, at_zero;
  logic             step_cd, step_rtc, step_ecnt, free_dn;

  function automatic logic pwm_level(input logic [DW-1:0] c, input logic [DW-1:0] t, input logic iv);
    return (c > t) ^ iv;
  endfunction

  always_comb begin
    msk       = wide ? '1 : {{CNT_W{1'b0}}, {CNT_W{1'b1}}};
    lim       = match_val & msk;
    upd       = (cnt_q + 1'b1) & msk;
    edge_ev   = edge_hit(edge_sel, pin, pin_q);
    is_cd     = !rtc_mode && (mode == MD_ONESHOT || mode == MD_PERIODIC);
    frozen    = is_cd && stall_en && halt;
    tick      = wide || (pre_q == '0);
    at_zero   = (cnt_q == '0);
    step_cd   = en && is_cd && !frozen && tick;
    step_rtc  = en && rtc_mode && rtc_tick;
    step_ecnt = en && !rtc_mode && mode == MD_EDGECNT && edge_ev;
    free_dn   = en && !rtc_mode && (mode == MD_EDGETIME || mode == MD_PWM);
    ev_timeout = step_cd && at_zero;
    ev_capture = en && !rtc_mode && mode == MD_EDGETIME && edge_ev;
    ev_match   = ((step_rtc || step_ecnt) && upd == lim) ||
                 (free_dn && mode == MD_PWM && cnt_q == lim);
    done       = ev_timeout && mode == MD_ONESHOT;
    pwm_o      = (!rtc_mode && mode == MD_PWM) ? pwm_level(cnt_q, lim, inv) : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pre_q <= '0;
      cap_q <= '0;
      pin_q <= 1'b0;
    end else begin
      pin_q <= pin;
      if (ev_capture) cap_q <= cnt_q;
      if (load_wr) begin
        cnt_q <= wr_val & msk;
        pre_q <= pre_val;
      end else begin
        if (en && is_cd && !frozen && !wide)
          pre_q <= (pre_q == '0) ? pre_val : pre_q - 1'b1;
        if (step_rtc || step_ecnt)
          cnt_q <= upd;
        else if (step_cd || free_dn) begin
          if (at_zero) cnt_q <= (is_cd && mode == MD_ONESHOT) ? '0 : (load_val & msk);
          else         cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign cnt = cnt_q;
  assign cap = cap_q;

  p_oneshot_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load_wr) |=> (cnt_q == '0));
  p_periodic_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_timeout && mode == MD_PERIODIC && !load_wr) |=> (cnt_q == $past(load_val & msk)));
  p_stall_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !load_wr) |=> ($stable(cnt_q) && $stable(pre_q)));
  p_capture_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_capture |=> (cap_q == $past(cnt_q)));
  p_load_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    load_wr |=> (cnt_q == $past(wr_val & msk)));
endmodule

// File: rtl/gp_timer_pair.sv
module gp_timer_pair import gpt_pkg::*; #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8,
  parameter int AW    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [2*CNT_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [2*CNT_W-1:0] rd_data,
  input  logic              ccp_a_i,
  input  logic              ccp_b_i,
  input  logic              rtc_tick_i,
  input  logic              dbg_halt_i,
  output logic              pwm_a_o,
  output logic              pwm_b_o,
  output logic              irq_o
);
  localparam int DW  = 2 * CNT_W;
  localparam int NH  = 2;
  localparam int NEV = 3 * NH;

  logic [CFG_W-1:0] cfg_q;
  logic [NH-1:0]    ctrl_q;
  logic [DW-1:0]    load_q  [NH];
  logic [DW-1:0]    match_q [NH];
  logic [PRE_W-1:0] pre_q   [NH];
  logic [NEV-1:0]   stat_q, mask_q, set_vec;
  logic [DW-1:0]    cnt_w [NH];
  logic [DW-1:0]    cap_w [NH];
  logic [NH-1:0]    done_v, pwm_v, pin_v;
  logic             ctrl_wr, stat_wr;

  assign pin_v   = {ccp_b_i, ccp_a_i};
  assign ctrl_wr = wr_en && wr_addr == AW'(A_CTRL);
  assign stat_wr = wr_en && wr_addr == AW'(A_STAT);

  for (genvar h = 0; h < NH; h++) begin : g_half
    logic hw_en, hw_wide, hw_rtc;
    assign hw_en   = ctrl_q[h] && !(h != 0 && cfg_q[CF_JOIN]);
    assign hw_wide = (h == 0) && cfg_q[CF_JOIN];
    assign hw_rtc  = hw_wide && cfg_q[CF_RTC];

    gpt_half #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_half (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (hw_en),
      .wide       (hw_wide),
      .rtc_mode   (hw_rtc),
      .mode       (cfg_q[CF_MODE+3*h +: 3]),
      .stall_en   (cfg_q[CF_STALL+h]),
      .halt       (dbg_halt_i),
      .inv        (cfg_q[CF_INV+h]),
      .edge_sel   (cfg_q[CF_EDGE+2*h +: 2]),
      .pin        (pin_v[h]),
      .rtc_tick   (rtc_tick_i),
      .load_wr    (wr_en && wr_addr == AW'(A_LOAD + h)),
      .wr_val     (wr_data),
      .load_val   (load_q[h]),
      .match_val  (match_q[h]),
      .pre_val    (pre_q[h]),
      .cnt        (cnt_w[h]),
      .cap        (cap_w[h]),
      .ev_timeout (set_vec[3*h]),
      .ev_capture (set_vec[3*h+1]),
      .ev_match   (set_vec[3*h+2]),
      .done       (done_v[h]),
      .pwm_o      (pwm_v[h])
    );

    p_oneshot_en_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (done_v[h] && !ctrl_wr) |=> !ctrl_q[h]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      ctrl_q <= '0;
      stat_q <= '0;
      mask_q <= '0;
      for (int h = 0; h < NH; h++) begin
        load_q[h]  <= '0;
        match_q[h] <= '0;
        pre_q[h]   <= '0;
      end
    end else begin
      if (wr_en && wr_addr == AW'(A_CFG))  cfg_q  <= wr_data[CFG_W-1:0];
      if (wr_en && wr_addr == AW'(A_MASK)) mask_q <= wr_data[NEV-1:0];
      for (int h = 0; h < NH; h++) begin
        if (wr_en && wr_addr == AW'(A_LOAD + h))  load_q[h]  <= wr_data;
        if (wr_en && wr_addr == AW'(A_MATCH + h)) match_q[h] <= wr_data;
        if (wr_en && wr_addr == AW'(A_PRE + h))   pre_q[h]   <= wr_data[PRE_W-1:0];
      end
      ctrl_q <= ctrl_wr ? wr_data[NH-1:0] : (ctrl_q & ~done_v);
      stat_q <= (stat_q & ~(stat_wr ? wr_data[NEV-1:0] : '0)) | set_vec;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      AW'(A_CFG):  rd_data = DW'(cfg_q);
      AW'(A_CTRL): rd_data = DW'(ctrl_q);
      AW'(A_STAT): rd_data = DW'(stat_q);
      AW'(A_MASK): rd_data = DW'(mask_q);
      default:     rd_data = '0;
    endcase
    for (int h = 0; h < NH; h++) begin
      if (rd_addr == AW'(A_LOAD + h))  rd_data = load_q[h];
      if (rd_addr == AW'(A_MATCH + h)) rd_data = match_q[h];
      if (rd_addr == AW'(A_PRE + h))   rd_data = DW'(pre_q[h]);
      if (rd_addr == AW'(A_CNT + h))   rd_data = cnt_w[h];
      if (rd_addr == AW'(A_CAP + h))   rd_data = cap_w[h];
    end
  end

  assign pwm_a_o = pwm_v[0];
  assign pwm_b_o = pwm_v[1];
  assign irq_o   = |(stat_q & mask_q);

  for (genvar b = 0; b < NEV; b++) begin : g_stat_chk
    p_stat_w1c_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && wr_data[b] && !set_vec[b]) |=> !stat_q[b]);
    p_stat_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[b] && !(stat_wr && wr_data[b])) |=> stat_q[b]);
    p_stat_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[b] |=> stat_q[b]);
  end
endmodule

// File: tb/gp_timer_pair_tb_top.sv
module gp_timer_pair_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        ccp_a = 1'b0, ccp_b = 1'b0, rtc_tick = 1'b0, halt = 1'b0;
  logic        pwm_a, pwm_b, irq;

  int    total = 0, bad = 0;
  bit    fin = 1'b0;
  bit    live = 1'b0;
  string cur_tag = "R1";

  always #5 clk = ~clk;

  gp_timer_pair dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ccp_a_i(ccp_a), .ccp_b_i(ccp_b),
    .rtc_tick_i(rtc_tick), .dbg_halt_i(halt), .pwm_a_o(pwm_a), .pwm_b_o(pwm_b), .irq_o(irq)
  );

  // behavioural reference state
  logic [15:0] m_cfg = '0;
  logic [1:0]  m_ctrl = '0;
  logic [5:0]  m_stat = '0, m_mask = '0;
  logic [31:0] m_load[2] = '{0, 0};
  logic [31:0] m_match[2] = '{0, 0};
  logic [7:0]  m_pre[2] = '{0, 0};
  logic [31:0] m_cnt[2] = '{0, 0};
  logic [31:0] m_cap[2] = '{0, 0};
  logic [7:0]  m_pc[2] = '{0, 0};
  logic        m_pq[2] = '{0, 0};

  function automatic logic [31:0] width_of(input bit wide);
    return wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  endfunction

  always @(posedge clk) begin : ref_model
    logic [5:0] sset;
    logic [1:0] dn;
    if (!rst_n) begin
      m_cfg = '0; m_ctrl = '0; m_stat = '0; m_mask = '0;
      for (int h = 0; h < 2; h++) begin
        m_load[h] = '0; m_match[h] = '0; m_pre[h] = '0;
        m_cnt[h] = '0; m_cap[h] = '0; m_pc[h] = '0; m_pq[h] = 1'b0;
      end
    end else begin
      sset = '0; dn = '0;
      for (int h = 0; h < 2; h++) begin
        bit jn, en, wide, rtc, cd, frz, hit, pin;
        int mode, esel;
        logic [31:0] mk, lim, c;
        jn   = m_cfg[0];
        en   = m_ctrl[h] && !(h == 1 && jn);
        wide = (h == 0) && jn;
        rtc  = wide && m_cfg[1];
        mode = (m_cfg >> (2 + 3*h)) & 7;
        esel = (m_cfg >> (12 + 2*h)) & 3;
        mk   = width_of(wide);
        lim  = m_match[h] & mk;
        c    = m_cnt[h];
        pin  = (h == 0) ? ccp_a : ccp_b;
        hit  = (esel == 0) ? (pin && !m_pq[h]) : (esel == 1) ? (!pin && m_pq[h]) : (pin != m_pq[h]);
        cd   = !rtc && mode < 2;
        frz  = cd && m_cfg[8+h] && halt;
        if (en && rtc) begin
          if (rtc_tick) begin
            m_cnt[h] = (c + 1) & mk;
            if (m_cnt[h] == lim) sset[3*h+2] = 1'b1;
          end
        end else if (en && cd && !frz) begin
          bit tk;
          tk = wide || m_pc[h] == 0;
          if (!wide) m_pc[h] = (m_pc[h] == 0) ? m_pre[h] : m_pc[h] - 1;
          if (tk) begin
            if (c == 0) begin
              sset[3*h] = 1'b1;
              if (mode == 0) begin m_cnt[h] = 0; dn[h] = 1'b1; end
              else m_cnt[h] = m_load[h] & mk;
            end else m_cnt[h] = c - 1;
          end
        end else if (en && !rtc && mode == 2) begin
          if (hit) begin
            m_cnt[h] = (c + 1) & mk;
            if (m_cnt[h] == lim) sset[3*h+2] = 1'b1;
          end
        end else if (en && !rtc && (mode == 3 || mode == 4)) begin
          if (mode == 3 && hit) begin m_cap[h] = c; sset[3*h+1] = 1'b1; end
          if (mode == 4 && c == lim) sset[3*h+2] = 1'b1;
          m_cnt[h] = (c == 0) ? (m_load[h] & mk) : c - 1;
        end
        if (wr_en && wr_addr == 4'(2 + h)) begin
          m_cnt[h] = wr_data & mk;
          m_pc[h]  = m_pre[h];
        end
        m_pq[h] = pin;
      end
      m_stat = (m_stat & ~((wr_en && wr_addr == 8) ? wr_data[5:0] : 6'd0)) | sset;
      m_ctrl = (wr_en && wr_addr == 1) ? wr_data[1:0] : (m_ctrl & ~dn);
      if (wr_en) begin
        case (wr_addr)
          0: m_cfg = wr_data[15:0];
          2: m_load[0] = wr_data;
          3: m_load[1] = wr_data;
          4: m_match[0] = wr_data;
          5: m_match[1] = wr_data;
          6: m_pre[0] = wr_data[7:0];
          7: m_pre[1] = wr_data[7:0];
          9: m_mask = wr_data[5:0];
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] m_read(input logic [3:0] a);
    case (a)
      0: return 32'(m_cfg);
      1: return 32'(m_ctrl);
      2: return m_load[0];
      3: return m_load[1];
      4: return m_match[0];
      5: return m_match[1];
      6: return 32'(m_pre[0]);
      7: return 32'(m_pre[1]);
      8: return 32'(m_stat);
      9: return 32'(m_mask);
      10: return m_cnt[0];
      11: return m_cnt[1];
      12: return m_cap[0];
      13: return m_cap[1];
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic m_pwm(input int h);
    bit wide, rtc;
    int mode;
    wide = (h == 0) && m_cfg[0];
    rtc  = wide && m_cfg[1];
    mode = (m_cfg >> (2 + 3*h)) & 7;
    if (rtc || mode != 4) return 1'b0;
    return (m_cnt[h] > (m_match[h] & width_of(wide))) ^ m_cfg[10+h];
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(posedge clk) begin
    #2;
    if (live) begin
      chk(rd_data == m_read(rd_addr), cur_tag, "rd_data", rd_data, m_read(rd_addr));
      chk(pwm_a == m_pwm(0), cur_tag, "pwm_a", 32'(pwm_a), 32'(m_pwm(0)));
      chk(pwm_b == m_pwm(1), cur_tag, "pwm_b", 32'(pwm_b), 32'(m_pwm(1)));
      chk(irq == |(m_stat & m_mask), cur_tag, "irq", 32'(irq), 32'(|(m_stat & m_mask)));
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_chk(input int a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rd_addr = 4'(a);
    #1;
    chk(rd_data == exp, tag, $sformatf("read addr %0d", a), rd_data, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ccp_a = 0; ccp_b = 0; rtc_tick = 0; halt = 0;
    idle(2);
    rst_n = 1'b1;
  endtask

  function automatic logic [31:0] cfgv(input bit jn, input bit rtc, input int ma, input int mb,
                                      input bit sa, input bit sb, input bit ia, input bit ib,
                                      input int ea, input int eb);
    return 32'(jn) | (32'(rtc) << 1) | (32'(ma) << 2) | (32'(mb) << 5) | (32'(sa) << 8) |
           (32'(sb) << 9) | (32'(ia) << 10) | (32'(ib) << 11) | (32'(ea) << 12) | (32'(eb) << 14);
  endfunction

  initial begin
    int hi_a, hi_b;
    live = 1'b1;
    // R1: reset state
    cur_tag = "R1";
    idle(2);
    for (int a = 0; a < 14; a++) rd_chk(a, 32'd0, "R1");
    chk(!pwm_a && !pwm_b && !irq, "R1", "outputs low", {pwm_a, pwm_b, irq}, 0);
    rst_n = 1'b1;

    // R2 / R4: one-shot on half 0, prescale 2
    cur_tag = "R4"; rd_addr = 10;
    wr(6, 2); wr(2, 5); wr(1, 1);
    idle(30);
    rd_chk(1, 32'd0, "R2");
    rd_chk(8, 32'd1, "R2");
    rd_chk(10, 32'd0, "R2");

    // R3 / R11: periodic on half 1, no prescale
    do_reset(); cur_tag = "R3"; rd_addr = 11;
    wr(0, cfgv(0, 0, 0, 1, 0, 0, 0, 0, 0, 0)); wr(3, 3); wr(9, 6'b001000); wr(1, 2);
    idle(20);
    rd_chk(1, 32'd2, "R3");
    chk(irq == 1'b1, "R11", "irq raised", 32'(irq), 1);
    cur_tag = "R11";
    wr(1, 0); wr(8, 32'h8);
    rd_chk(8, 32'd0, "R11");
    chk(irq == 1'b0, "R11", "irq cleared", 32'(irq), 0);

    // R5: joined one-shot across the 16-bit boundary, half 1 must stay idle
    do_reset(); cur_tag = "R5"; rd_addr = 10;
    wr(0, cfgv(1, 0, 0, 0, 0, 0, 0, 0, 0, 0)); wr(6, 5); wr(2, 32'h0001_0001); wr(1, 3);
    idle(65600);
    rd_chk(1, 32'd2, "R5");
    rd_chk(8, 32'd1, "R5");

    // R6: real-time clock counting
    do_reset(); cur_tag = "R6"; rd_addr = 10;
    wr(0, cfgv(1, 1, 0, 0, 0, 0, 0, 0, 0, 0)); wr(4, 4); wr(1, 1);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); rtc_tick = 1'b1;
      @(negedge clk); rtc_tick = 1'b0;
      idle(1);
    end
    rd_chk(10, 32'd6, "R6");
    rd_chk(8, 32'd4, "R6");

    // R7: stall on half 0 only; then R12 load write in mid-count
    do_reset(); cur_tag = "R7"; rd_addr = 10;
    wr(0, cfgv(0, 0, 1, 1, 1, 0, 0, 0, 0, 0)); wr(2, 20); wr(3, 20);
    halt = 1'b1;
    wr(1, 3);
    idle(10);
    rd_chk(10, 32'd20, "R7");
    halt = 1'b0;
    idle(7);
    cur_tag = "R12";
    wr(2, 50);
    rd_chk(10, 32'd49, "R12");

    // R8: edge counting, rising on half 0, both edges on half 1
    do_reset(); cur_tag = "R8"; rd_addr = 11;
    wr(0, cfgv(0, 0, 2, 2, 0, 0, 0, 0, 0, 2)); wr(4, 3); wr(1, 3);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); ccp_a = 1; ccp_b = 1;
      idle(2); ccp_a = 0; ccp_b = 0;
      idle(2);
    end
    rd_chk(10, 32'd3, "R8");
    rd_chk(11, 32'd6, "R8");
    rd_chk(8, 32'd4, "R8");
    // falling-edge select
    wr(0, cfgv(0, 0, 2, 2, 0, 0, 0, 0, 1, 2));
    @(negedge clk); ccp_a = 1; idle(3); ccp_a = 0; idle(3);
    rd_chk(10, 32'd4, "R8");

    // R9: edge time capture
    do_reset(); cur_tag = "R9"; rd_addr = 12;
    wr(0, cfgv(0, 0, 3, 0, 0, 0, 0, 0, 0, 0)); wr(2, 100); wr(1, 1);
    idle(10);
    @(negedge clk); ccp_a = 1; idle(3); ccp_a = 0; idle(3);
    rd_chk(8, 32'd2, "R9");

    // R10: PWM, half 1 inverted
    do_reset(); cur_tag = "R10"; rd_addr = 10;
    wr(0, cfgv(0, 0, 4, 4, 0, 0, 0, 1, 0, 0));
    wr(2, 7); wr(3, 7); wr(4, 2); wr(5, 2); wr(9, 6'b100100); wr(1, 3);
    idle(3);
    hi_a = 0; hi_b = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); #1;
      hi_a += pwm_a; hi_b += pwm_b;
    end
    chk(hi_a == 5, "R10", "high cycles A", 32'(hi_a), 5);
    chk(hi_b == 3, "R10", "high cycles B", 32'(hi_b), 3);
    chk(irq == 1'b1, "R10", "match irq", 32'(irq), 1);
    cur_tag = "R11";
    wr(8, 32'h3F);
    idle(12);

    fin = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      total++; bad++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule